// File: doc/BRIEF.md
# Line-Approximated Sine Amplitude Converter

This block turns the top bits of a frequency-synthesis phase accumulator into a 9-bit sine sample in offset-binary form. It is meant to sit between the accumulator and a D/A converter. Two copies can run side by side on alternate phase samples to double the sample rate. It does not use a full sine table. The phase is first folded into one quarter wave. Four straight chords are laid across that quarter wave. Two small constant tables then add back the gap between the chord and the sine.

The gap tables are split by address and by magnitude. A coarse table keeps one 3-bit value for each group of eight folded phases. A fine table keeps one bit per folded phase, worth two amplitude steps. Their sum lands within one LSB of the gap. All table contents and chord constants are computed while the design elaborates, from a rounded integer sine. Total table storage is 352 bits, below the 368-bit budget set for a 9-bit output. The datapath is pipelined, accepts a new phase on every clock, and has a fixed latency.

Top module: `qline_sine_conv`

## Requirements
- R1: While `rst` is high at a rising edge, `amp_out` reads 256 (mid-scale) after that edge. When reset is released, the output again follows the phase input after the normal pipeline latency.
- R2: A phase word sampled at a rising edge appears on `amp_out` after the third rising edge, counting the sampling edge as the first. A new phase word is accepted on every clock. If the phase is held steady, the output stays steady.
- R3: For phase p, let m = round(255·|sin(2π(p+0.5)/1024)|). The expected output is 256+m when phase bit 9 is 0 and 255−m when phase bit 9 is 1. `amp_out` must be within ±1 of this value for all 1024 phases.
- R4: Odd symmetry holds exactly: out(p) + out(p XOR 512) = 511 for every phase p.
- R5: Quarter-wave mirroring holds exactly: out(p) = out(p XOR 511) for every phase p. Setting phase bit 8 replaces the low 8 bits with their one's complement.
- R6: Bit 8 of `amp_out` is always the inverse of bit 9 of the phase that produced it. The magnitude saturates at 255 and never wraps across mid-scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_in | input | 10 | Truncated phase word; bit 9 is the half-cycle, bit 8 the mirrored quarter |
| amp_out | output | 9 | Registered sine sample, offset binary |

## Verification
The bench goes after the quarter-wave seams. At phases 255/256 and 767/768 the magnitude peaks. A missing clamp there would make the output wrap to the wrong side of mid-scale. At phases 0, 511, 512 and 1023 a fold that gets the complement wrong would break the exact mirror and half-cycle sums. It sweeps every phase, which exposes a chord constant or a table entry that drifts by more than one LSB at a segment or group boundary. A step test and a back-to-back stream catch any extra or missing pipeline stage. A reset asserted mid-stream must pull the output to 256, which flags a stale register left out of reset.

// File: rtl/qline_sine_pkg.sv
package qline_sine_pkg;

  // Fixed-point helpers for elaboration-time constant generation.
  localparam int     FRAC = 30;
  localparam longint ONE  = 64'sd1 <<< FRAC;
  localparam longint PI_Q = 64'sd3373259426;  // pi in Q30

  // sin(k*pi / 2^lg) in Q30, valid for angles in [0, pi/2]
  function automatic longint sin_q(input longint k, input int lg);
    longint x;
    longint x2;
    longint t;
    x  = (k * PI_Q) >>> lg;
    x2 = (x * x) >>> FRAC;
    t  = ONE - x2 / 110;
    t  = ONE - ((x2 * t) >>> FRAC) / 72;
    t  = ONE - ((x2 * t) >>> FRAC) / 42;
    t  = ONE - ((x2 * t) >>> FRAC) / 20;
    t  = ONE - ((x2 * t) >>> FRAC) / 6;
    return (x * t) >>> FRAC;
  endfunction

  // round(full * sin(k*pi/2^lg))
  function automatic int scaled_sin(input longint k, input int lg, input int full);
    longint p;
    p = longint'(full) * sin_q(k, lg) + (ONE >>> 1);
    return int'(p >>> FRAC);
  endfunction

  // magnitude of folded sample f (half-step phase offset)
  function automatic int fold_mag(input int f, input int qb, input int full);
    return scaled_sin(longint'(2 * f + 1), qb + 2, full);
  endfunction

  // chord end point s of 2^sb segments across the quarter wave
  function automatic int anchor(input int s, input int qb, input int sb, input int full);
    return scaled_sin(longint'(s) <<< (qb - sb + 1), qb + 2, full);
  endfunction

  // rounded chord value at folded phase f (same arithmetic as the hardware)
  function automatic int line_at(input int f, input int qb, input int sb, input int full);
    int slb;
    int s;
    int o;
    int a;
    int d;
    slb = qb - sb;
    s   = f >> slb;
    o   = f & ((1 << slb) - 1);
    a   = anchor(s, qb, sb, full);
    d   = anchor(s + 1, qb, sb, full) - a;
    return a + ((d * o + (1 << (slb - 1))) >>> slb);
  endfunction

endpackage

// File: rtl/qs_fold.sv
module qs_fold #(
  parameter int PHASE_W = 10,
  parameter int QB      = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase_in,
  output logic [QB-1:0]      fold_q,
  output logic               neg_q
);

  // Stage 1: quarter-wave fold; the second quarter of each half is mirrored.
  always_ff @(posedge clk) begin
    if (rst) begin
      fold_q <= '0;
      neg_q  <= 1'b0;
    end else begin
      fold_q <= phase_in[QB] ? ~phase_in[QB-1:0] : phase_in[QB-1:0];
      neg_q  <= phase_in[PHASE_W-1];
    end
  end

endmodule

// File: rtl/qs_seg_line.sv
module qs_seg_line import qline_sine_pkg::*; #(
  parameter int QB    = 8,
  parameter int SB    = 2,
  parameter int MAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [QB-1:0]    fold_in,
  output logic [MAG_W-1:0] line_q
);

  localparam int SLB  = QB - SB;
  localparam int NSEG = 1 << SB;
  localparam int FULL = (1 << MAG_W) - 1;
  localparam int PW   = MAG_W + SLB + 1;

  logic [SLB-1:0]   off;
  logic [MAG_W-1:0] cand [NSEG];
  logic             valid_q;

  assign off = fold_in[SLB-1:0];

  // One constant-coefficient chord per segment; the multiply reduces to shift-add.
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam int A = anchor(s, QB, SB, FULL);
    localparam int D = anchor(s + 1, QB, SB, FULL) - A;
    logic [PW-1:0] prod;
    assign prod    = PW'(D) * PW'(off) + PW'(1 << (SLB - 1));
    assign cand[s] = MAG_W'(A) + MAG_W'(prod >> SLB);
  end

  // Stage 2: registered chord value
  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      line_q  <= cand[fold_in[QB-1:SLB]];
      valid_q <= 1'b1;
    end
  end

  // The chain of chords rises with the folded phase (R3)
  assert_line_monotone_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_q && ($past(fold_in) >= $past(fold_in, 2))) |-> (line_q >= $past(line_q)));

endmodule

// File: rtl/qs_resid_rom.sv
module qs_resid_rom import qline_sine_pkg::*; #(
  parameter int QB    = 8,
  parameter int SB    = 2,
  parameter int GB    = 3,
  parameter int CW    = 3,
  parameter int MAG_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [QB-1:0] addr,
  output logic [CW-1:0] coarse_q,
  output logic          fine_q
);

  localparam int NG   = 1 << (QB - GB);
  localparam int NF   = 1 << QB;
  localparam int GS   = 1 << GB;
  localparam int FULL = (1 << MAG_W) - 1;

  logic [CW-1:0] coarse_mem [NG];
  logic          fine_mem   [NF];

  // Gap between sine and chord, split into a per-group base and a 2-step bit.
  initial begin
    for (int g = 0; g < NG; g++) begin
      int mn;
      int r;
      int q;
      mn = 1 << 20;
      for (int j = 0; j < GS; j++) begin
        r = fold_mag(g * GS + j, QB, FULL) - line_at(g * GS + j, QB, SB, FULL);
        if (r < mn) mn = r;
      end
      q = mn + 1;
      coarse_mem[g] = CW'(q);
      for (int j = 0; j < GS; j++) begin
        r = fold_mag(g * GS + j, QB, FULL) - line_at(g * GS + j, QB, SB, FULL);
        fine_mem[g * GS + j] = ((r - q) >= 2);
      end
    end
  end

  // Stage 2: registered table reads (block-RAM style)
  always_ff @(posedge clk) begin
    if (rst) begin
      coarse_q <= '0;
      fine_q   <= 1'b0;
    end else begin
      coarse_q <= coarse_mem[addr[QB-1:GB]];
      fine_q   <= fine_mem[addr];
    end
  end

endmodule

// File: rtl/qline_sine_conv.sv
module qline_sine_conv #(
  parameter int PHASE_W    = 10,
  parameter int AMP_W      = 9,
  parameter int SEG_BITS   = 2,
  parameter int GROUP_BITS = 3,
  parameter int COARSE_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase_in,
  output logic [AMP_W-1:0]   amp_out
);

  localparam int QB    = PHASE_W - 2;
  localparam int MAG_W = AMP_W - 1;
  localparam int FULL  = (1 << MAG_W) - 1;
  localparam int SUM_W = AMP_W + 1;
  localparam logic [AMP_W-1:0] MID = AMP_W'(1 << MAG_W);

  logic [QB-1:0]       fold_q;
  logic                neg1_q;
  logic                neg2_q;
  logic [MAG_W-1:0]    line_q;
  logic [COARSE_W-1:0] coarse_q;
  logic                fine_q;
  logic [SUM_W-1:0]    sum;
  logic [MAG_W-1:0]    mag_sat;
  logic [2:0]          warm;
  logic                rst_q;

  qs_fold #(.PHASE_W(PHASE_W), .QB(QB)) u_fold (
    .clk(clk), .rst(rst), .phase_in(phase_in), .fold_q(fold_q), .neg_q(neg1_q)
  );

  qs_seg_line #(.QB(QB), .SB(SEG_BITS), .MAG_W(MAG_W)) u_line (
    .clk(clk), .rst(rst), .fold_in(fold_q), .line_q(line_q)
  );

  qs_resid_rom #(.QB(QB), .SB(SEG_BITS), .GB(GROUP_BITS), .CW(COARSE_W), .MAG_W(MAG_W)) u_rom (
    .clk(clk), .rst(rst), .addr(fold_q), .coarse_q(coarse_q), .fine_q(fine_q)
  );

  always_ff @(posedge clk) begin
    if (rst) neg2_q <= 1'b0;
    else     neg2_q <= neg1_q;
  end

  // Stage 3: rebuild magnitude, clamp at full scale, restore the half cycle
  assign sum     = SUM_W'(line_q) + SUM_W'(coarse_q) + (fine_q ? SUM_W'(2) : SUM_W'(0));
  assign mag_sat = (sum > SUM_W'(FULL)) ? MAG_W'(FULL) : sum[MAG_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) amp_out <= MID;
    else     amp_out <= neg2_q ? {1'b0, ~mag_sat} : {1'b1, mag_sat};
  end

  // Cycles since reset, for assertions that look back
  always_ff @(posedge clk) begin
    if (rst)               warm <= '0;
    else if (warm != 3'd7) warm <= warm + 3'd1;
    rst_q <= rst;
  end

  // R1: a reset edge leaves mid-scale on the output
  always @(posedge clk) begin
    if (rst_q === 1'b1) begin
      assert_reset_mid_R1: assert (amp_out == MID);
    end
  end

  // R3: line plus gap overshoots full scale by at most one step
  assert_sum_bound_R3: assert property (@(posedge clk) disable iff (rst)
    sum <= SUM_W'(FULL + 1));

  // R6: the half-cycle bit survives three stages untouched
  assert_sign_path_R6: assert property (@(posedge clk) disable iff (rst)
    (warm >= 3'd3) |-> (amp_out[AMP_W-1] == ~$past(phase_in[PHASE_W-1], 3)));

  // R2: a held phase gives a held output
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    ((warm >= 3'd4) && ($past(phase_in, 3) == $past(phase_in, 4))) |-> $stable(amp_out));

endmodule

// File: tb/tb_qline_sine_conv.sv
`timescale 1ns/1ps
module tb_qline_sine_conv;

  localparam int PW = 10;
  localparam int AW = 9;
  localparam int N  = 1 << PW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PW-1:0] phase = '0;
  logic [AW-1:0] amp;

  int checks = 0;
  int fails  = 0;
  int outs [N];

  // {phase, hand-computed rounded ideal}
  localparam int VEC [14][2] = '{
    '{0, 257}, '{255, 511}, '{256, 511}, '{511, 257}, '{512, 254}, '{767, 0},
    '{768, 0}, '{1023, 254}, '{128, 437}, '{64, 354}, '{192, 492}, '{640, 74},
    '{896, 75}, '{384, 436}
  };

  localparam int SEQ [12] = '{3, 700, 256, 1023, 511, 0, 300, 767, 128, 900, 512, 45};

  qline_sine_conv dut (.clk(clk), .rst(rst), .phase_in(phase), .amp_out(amp));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ideal(input int p);
    real s;
    int  m;
    s = $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / real'(N));
    if (s < 0.0) s = -s;
    m = $rtoi(255.0 * s + 0.5);
    return (p >= N / 2) ? 255 - m : 256 + m;
  endfunction

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic apply(input int p);
    @(negedge clk);
    phase = PW'(p);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    chk(amp == 9'd256, "R1 reset mid-scale", int'(amp), 256);
    @(negedge clk);
    rst = 1'b0;

    // vector table, R3
    for (int i = 0; i < 14; i++) begin
      apply(VEC[i][0]);
      chk(absd(int'(amp), VEC[i][1]) <= 1, $sformatf("R3 vector phase %0d", VEC[i][0]),
          int'(amp), VEC[i][1]);
    end

    // full sweep, R3 and R6
    for (int p = 0; p < N; p++) begin
      apply(p);
      outs[p] = int'(amp);
      chk(absd(int'(amp), ideal(p)) <= 1, $sformatf("R3 sweep phase %0d", p), int'(amp), ideal(p));
      chk(amp[AW-1] == (p < N / 2), $sformatf("R6 sign phase %0d", p),
          int'(amp[AW-1]), int'(p < N / 2));
    end

    // R4 odd symmetry
    for (int p = 0; p < N / 2; p++)
      chk(outs[p] + outs[p + N / 2] == 511, $sformatf("R4 half-cycle sum phase %0d", p),
          outs[p] + outs[p + N / 2], 511);

    // R5 quarter mirror
    for (int p = 0; p < N; p++)
      chk(outs[p] == outs[p ^ 511], $sformatf("R5 mirror phase %0d", p), outs[p], outs[p ^ 511]);

    // R2 latency step
    apply(0);
    @(negedge clk);
    phase = 10'd767;
    for (int k = 1; k <= 3; k++) begin
      @(posedge clk);
      #1;
      if (k < 3) chk(int'(amp) == outs[0], $sformatf("R2 step edge %0d", k), int'(amp), outs[0]);
      else       chk(int'(amp) == outs[767], "R2 step edge 3", int'(amp), outs[767]);
    end

    // R2 one word per clock
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (i >= 3)
        chk(int'(amp) == outs[SEQ[i-3]], $sformatf("R2 stream slot %0d", i - 3),
            int'(amp), outs[SEQ[i-3]]);
      if (i < 12) phase = PW'(SEQ[i]);
    end

    // R1 mid-stream reset and recovery
    apply(255);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk(amp == 9'd256, "R1 mid-stream reset", int'(amp), 256);
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(int'(amp) == outs[255], "R1 recovery after reset", int'(amp), outs[255]);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule